// File: doc/BRIEF.md
# Two-Wire ADC Configure-and-Sample Master

This block is the bus controller for a two-channel 10-bit converter that sits on a two-wire I2C bus. The user logic pulses `start`. The first accepted request after reset programs the converter. It sends one write transaction that carries the setup byte and then the configuration byte. Without returning to idle, the block then performs a read transaction. Each later request performs only the read. A read sends the read address and lets SCL run for a fixed number of conversion periods. It then clocks in two bytes, high byte first, and delivers the low bits as a sample on `result` with a one-cycle `done` pulse.

Both lines are open-drain. The block never drives a line high. It asserts `scl_oe` or `sda_oe` to pull the line low and releases the line otherwise. `sda_i` carries the level seen on the data wire. The SCL frequency comes from a divider on the system clock. Every SCL period is built from four equal quarter phases, so START, STOP and data edges each keep at least a quarter period of setup and hold.

An acknowledge slot that reads high ends the transaction at once with STOP. It also sets a sticky error flag. A failed programming write leaves the converter unprogrammed, so the next request repeats the write.

Top module: `adc_i2c_master`

## Requirements
- R1: During and straight after reset, `busy`, `done` and `nack_err` are 0, `result` is 0, and `scl_oe` and `sda_oe` are both 0 (lines released).
- R2: Within a transaction, every SCL high pulse that begins with a rising SCL edge lasts exactly 2*Q system clocks, where Q = CLK_HZ/(4*SCL_HZ).
- R3: Whenever `busy` is 0, both `scl_oe` and `sda_oe` are 0.
- R4: SDA changes level only while SCL is low, with two exceptions. SDA may fall with SCL high to open a transaction (START), and SDA may rise with SCL high to close one (STOP).
- R5: The first accepted start after reset produces a write transaction. It carries the bytes 0x6C (7-bit address 0110110, direction bit 0), then 0xD2 (setup), then 0x61 (configuration). Each byte goes MSB first and is followed by a ninth clock in which SDA is released. The transaction uses 27 SCL pulses and ends with STOP. It is followed within the same busy period by a read transaction.
- R6: Once a write has completed with all three acknowledges, each later start produces only a read transaction.
- R7: A read transaction sends 0x6D (address, direction bit 1) and takes its acknowledge. It then gives CONV_PERIODS SCL pulses with SDA released. Next it receives a high byte, drives a low (ack) in that byte's ninth clock, receives a low byte, and releases SDA (no-ack) in that byte's ninth clock. STOP follows, for 27+CONV_PERIODS SCL pulses in total.
- R8: After a successful read, `result` equals the low SAMPLE_W bits of {high byte, low byte}. `done` is high for exactly one cycle, in the first cycle in which `busy` is 0. `result` changes only together with `done`.
- R9: In every clock where the slave may drive SDA, the master keeps `sda_oe` at 0. These are the ack slots after transmitted bytes, the conversion periods and the received data bits.
- R10: A 1 read in an acknowledge slot stops SCL clocking after that slot and issues STOP. `busy` then falls with no `done` pulse and `result` keeps its old value. `nack_err` becomes 1 and stays 1 until reset.
- R11: If a write is aborted, the next accepted start runs the full write again before the read.
- R12: `start` is ignored while `busy` is 1: it produces no extra transaction and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse when a new sample is stored |
| nack_err | output | 1 | Sticky flag: an acknowledge was missing |
| result | output | SAMPLE_W | Latest converted sample |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Level observed on the data line |

## Verification
The bench builds the block with CLK_HZ = 4.8 MHz and SCL_HZ = 400 kHz, which gives a quarter phase of three system clocks. It keeps CONV_PERIODS at 4, SAMPLE_W at 10 and a two-stage input synchroniser. The short quarter makes each transaction a few hundred cycles long. That leaves room for a first run that programs and reads, several reads with all-ones, all-zeros and mixed samples, and read-address and setup-byte refusals with their retry. It is also long enough to show that the synchroniser delay still meets the sample point, since the slave answers only three quarters plus one clock before it.

// File: rtl/adc_i2c_pkg.sv
`timescale 1ns/1ps
package adc_i2c_pkg;

   typedef enum logic [1:0] {SYM_START, SYM_BIT, SYM_STOP} sym_e;

   typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_BYTE, SQ_WAIT, SQ_STOP} seq_e;

   localparam logic [6:0] DEV_ADDR    = 7'b0110110;
   localparam logic [7:0] ADDR_WR     = {DEV_ADDR, 1'b0};
   localparam logic [7:0] ADDR_RD     = {DEV_ADDR, 1'b1};
   localparam logic [7:0] SETUP_BYTE  = 8'b1101_0010;
   localparam logic [7:0] CONFIG_BYTE = 8'b0110_0001;

   // {scl pull-low, sda pull-low} for a symbol in a given quarter
   function automatic logic [1:0] line_drive(sym_e sym, logic [1:0] qtr, logic txb);
      logic [1:0] pull;
      pull = 2'b00;
      case (sym)
         SYM_START: begin
            case (qtr)
               2'd0, 2'd1: pull = 2'b00;
               2'd2:       pull = 2'b01;
               default:    pull = 2'b11;
            endcase
         end
         SYM_STOP: begin
            case (qtr)
               2'd0:    pull = 2'b11;
               2'd1:    pull = 2'b01;
               default: pull = 2'b00;
            endcase
         end
         default: begin
            pull[0] = ~txb;
            pull[1] = (qtr == 2'd0) || (qtr == 2'd3);
         end
      endcase
      return pull;
   endfunction

endpackage

// File: rtl/adc_i2c_qtimer.sv
`timescale 1ns/1ps
module adc_i2c_qtimer #(
   parameter int QTR = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (QTR > 1) ? $clog2(QTR) : 1;

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt == CNT_W'(QTR - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt <= '0;
      else                        cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/adc_i2c_sync.sv
`timescale 1ns/1ps
module adc_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)      chain[i] <= 1'b1;
               else if (i == 0) chain[i] <= d;
               else             chain[i] <= chain[(i > 0) ? i - 1 : 0];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_i2c_symbol.sv
`timescale 1ns/1ps
module adc_i2c_symbol
   import adc_i2c_pkg::*;
#(
   parameter int QTR = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  sym_e sym,
   input  logic txb,
   input  logic rx_line,
   output logic fin,
   output logic rxb,
   output logic scl_oe,
   output logic sda_oe
);
   logic       act;
   sym_e       cur;
   logic       ctx;
   logic [1:0] qtr;
   logic [1:0] held;
   logic       tick;

   adc_i2c_qtimer #(.QTR(QTR)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (act),
      .tick (tick)
   );

   assign fin = act && tick && (qtr == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         cur  <= SYM_STOP;
         ctx  <= 1'b1;
         qtr  <= 2'd0;
         held <= 2'b00;
         rxb  <= 1'b1;
      end else if (!act) begin
         if (req) begin
            act <= 1'b1;
            cur <= sym;
            ctx <= txb;
            qtr <= 2'd0;
         end
      end else if (tick) begin
         if (qtr == 2'd1) rxb <= rx_line;
         if (qtr == 2'd3) begin
            act  <= 1'b0;
            held <= line_drive(cur, qtr, ctx);
         end
         qtr <= qtr + 2'd1;
      end
   end

   assign {scl_oe, sda_oe} = act ? line_drive(cur, qtr, ctx) : held;
endmodule

// File: rtl/adc_i2c_master.sv
`timescale 1ns/1ps
module adc_i2c_master
   import adc_i2c_pkg::*;
#(
   parameter int CLK_HZ       = 200_000_000,
   parameter int SCL_HZ       = 400_000,
   parameter int CONV_PERIODS = 4,
   parameter int SAMPLE_W     = 10,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                busy,
   output logic                done,
   output logic                nack_err,
   output logic [SAMPLE_W-1:0] result,
   output logic                scl_oe,
   output logic                sda_oe,
   input  logic                sda_i
);
   localparam int QTR    = CLK_HZ / (4 * SCL_HZ);
   localparam int WAIT_W = $clog2(CONV_PERIODS + 1);
   localparam int HI_W   = SAMPLE_W - 8;

   generate
      if (QTR < 2) begin : g_bad_div
         $error("quarter phase must span at least two clocks");
      end
      if (CONV_PERIODS < 1) begin : g_bad_conv
         $error("at least one conversion period required");
      end
      if (SAMPLE_W < 9 || SAMPLE_W > 16) begin : g_bad_width
         $error("sample width must lie in 9..16");
      end
   endgenerate

   seq_e              state;
   logic              rd_txn;
   logic              configured;
   logic              failed;
   logic [1:0]        byte_no;
   logic [3:0]        bit_no;
   logic [7:0]        shreg;
   logic [HI_W-1:0]   hi_keep;
   logic [WAIT_W-1:0] wait_cnt;
   logic              rx_byte;
   sym_e              sym;
   logic              txb;
   logic              fin;
   logic              rxb;
   logic              sda_s;

   adc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sda_i),
      .q    (sda_s)
   );

   adc_i2c_symbol #(.QTR(QTR)) u_sym (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (state != SQ_IDLE),
      .sym    (sym),
      .txb    (txb),
      .rx_line(sda_s),
      .fin    (fin),
      .rxb    (rxb),
      .scl_oe (scl_oe),
      .sda_oe (sda_oe)
   );

   assign busy    = (state != SQ_IDLE);
   assign rx_byte = rd_txn && (byte_no != 2'd0);

   always_comb begin
      sym = SYM_BIT;
      txb = 1'b1;
      case (state)
         SQ_START: sym = SYM_START;
         SQ_STOP:  sym = SYM_STOP;
         SQ_BYTE: begin
            if (bit_no != 4'd8) txb = rx_byte ? 1'b1 : shreg[7];
            else                txb = rx_byte ? (byte_no == 2'd2) : 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         rd_txn     <= 1'b0;
         configured <= 1'b0;
         failed     <= 1'b0;
         byte_no    <= 2'd0;
         bit_no     <= 4'd0;
         shreg      <= 8'd0;
         hi_keep    <= '0;
         wait_cnt   <= '0;
         done       <= 1'b0;
         nack_err   <= 1'b0;
         result     <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            SQ_IDLE: if (start) begin
               state   <= SQ_START;
               rd_txn  <= configured;
               shreg   <= configured ? ADDR_RD : ADDR_WR;
               byte_no <= 2'd0;
               bit_no  <= 4'd0;
               failed  <= 1'b0;
            end
            SQ_START: if (fin) state <= SQ_BYTE;
            SQ_BYTE: if (fin) begin
               if (bit_no != 4'd8) begin
                  shreg  <= {shreg[6:0], rxb};
                  bit_no <= bit_no + 4'd1;
               end else begin
                  bit_no <= 4'd0;
                  if (!rx_byte && rxb) begin
                     failed   <= 1'b1;
                     nack_err <= 1'b1;
                     state    <= SQ_STOP;
                  end else if (!rd_txn) begin
                     if (byte_no == 2'd2) state <= SQ_STOP;
                     else begin
                        byte_no <= byte_no + 2'd1;
                        shreg   <= (byte_no == 2'd0) ? SETUP_BYTE : CONFIG_BYTE;
                     end
                  end else if (byte_no == 2'd0) begin
                     byte_no <= 2'd1;
                     state   <= SQ_WAIT;
                  end else if (byte_no == 2'd1) begin
                     hi_keep <= shreg[HI_W-1:0];
                     byte_no <= 2'd2;
                  end else begin
                     state <= SQ_STOP;
                  end
               end
            end
            SQ_WAIT: if (fin) begin
               if (wait_cnt == WAIT_W'(CONV_PERIODS - 1)) begin
                  wait_cnt <= '0;
                  state    <= SQ_BYTE;
               end else begin
                  wait_cnt <= wait_cnt + WAIT_W'(1);
               end
            end
            SQ_STOP: if (fin) begin
               if (failed) begin
                  state <= SQ_IDLE;
               end else if (!rd_txn) begin
                  configured <= 1'b1;
                  rd_txn     <= 1'b1;
                  shreg      <= ADDR_RD;
                  byte_no    <= 2'd0;
                  state      <= SQ_START;
               end else begin
                  result <= {hi_keep, shreg};
                  done   <= 1'b1;
                  state  <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_i2c_master_chk.sv
`timescale 1ns/1ps
module adc_i2c_master_chk #(
   parameter int SAMPLE_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic                nack_err,
   input logic [SAMPLE_W-1:0] result,
   input logic                scl_oe,
   input logic                sda_oe
);
   a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (result != $past(result)) |-> done);

   a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      nack_err |=> nack_err);

   a_r4_sda_edge_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> busy);
endmodule

bind adc_i2c_master adc_i2c_master_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .nack_err(nack_err),
   .result  (result),
   .scl_oe  (scl_oe),
   .sda_oe  (sda_oe)
);

// File: tb/adc_i2c_master_test.sv
`timescale 1ns/1ps
module adc_i2c_master_test;
   localparam int Q    = 3;
   localparam int CONV = 4;
   localparam int SW   = 10;
   localparam int D0   = 10 + CONV;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, done, nack_err, scl_oe, sda_oe, sda_i;
   logic [SW-1:0] result;

   int checks = 0, errors = 0, cyc = 0, done_cnt = 0;

   logic slv_pull = 1'b0;
   logic [SW-1:0] smp = '0;
   int nack_wr = 0, nack_rd = 0;
   logic bits [1:64];
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   bit in_txn = 0, hi_valid = 0, saw_start = 0;
   int rises = 0, hi_cnt = 0;
   int lg_rd[$], lg_rises[$], lg_b0[$], lg_b1[$], lg_b2[$], lg_mack[$], lg_mnack[$];

   assign sda_i = !(sda_oe || slv_pull);

   adc_i2c_master #(
      .CLK_HZ(4_800_000), .SCL_HZ(400_000), .CONV_PERIODS(CONV),
      .SAMPLE_W(SW), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .nack_err(nack_err), .result(result), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .sda_i(sda_i)
   );

   always #2.5 clk = ~clk;

   task automatic chk_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int byte_at(int a);
      int v = 0;
      for (int i = 0; i < 8; i++) v = (v << 1) | ((bits[a + i] === 1'b1) ? 1 : 0);
      return v;
   endfunction

   // slave model: pull-low decision for the bit clocked at rise r
   function automatic logic drive_for(int r);
      logic [7:0] hb, lb;
      hb = 8'(smp >> 8);
      lb = smp[7:0];
      if (r <= 8) return 1'b0;
      if (bits[8] !== 1'b1) return ((r == 9 || r == 18 || r == 27) && r != nack_wr);
      if (r == 9) return (nack_rd != 9);
      if (r >= D0 && r <= D0 + 7) return !hb[7 - (r - D0)];
      if (r >= D0 + 9 && r <= D0 + 16) return !lb[7 - (r - D0 - 9)];
      return 1'b0;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // per-clock bus monitor and reference comparison
   always @(negedge clk) begin
      logic cs, cd;
      cyc++;
      cs = !scl_oe;
      cd = sda_i;
      chk_eq("R3 lines released while idle", int'(!busy && (scl_oe || sda_oe)), 0);
      if (cs) chk_eq("R9 master released during slave drive", int'(slv_pull && sda_oe), 0);
      if (done) begin
         done_cnt++;
         chk_eq("R8 done only with busy low", int'(busy), 0);
      end
      if (prev_scl && cs && (cd != prev_sda)) begin
         if (!cd) begin
            chk_eq("R4 START only outside a transaction", int'(in_txn), 0);
            in_txn = 1; rises = 0; saw_start = 1;
         end else begin
            chk_eq("R4 STOP only inside a transaction", int'(in_txn), 1);
            if (in_txn) begin
               lg_rd.push_back((bits[8] === 1'b1) ? 1 : 0);
               lg_rises.push_back(rises - 1);
               lg_b0.push_back(byte_at(1));
               lg_b1.push_back(byte_at(10));
               lg_b2.push_back(byte_at(19));
               lg_mack.push_back((bits[D0 + 8] === 1'b1) ? 1 : 0);
               lg_mnack.push_back((bits[D0 + 17] === 1'b1) ? 1 : 0);
            end
            in_txn = 0; slv_pull = 1'b0;
         end
      end
      if (!prev_scl && cs) begin
         hi_cnt = 1; hi_valid = 1; saw_start = 0;
         if (in_txn) begin
            rises++;
            if (rises <= 64) bits[rises] = cd;
         end
      end else if (cs) begin
         hi_cnt++;
      end
      if (prev_scl && !cs) begin
         if (hi_valid && !saw_start) chk_eq("R2 SCL high time", hi_cnt, 2 * Q);
         hi_valid = 0;
         if (in_txn) slv_pull = drive_for(rises + 1);
      end
      prev_scl = cs;
      prev_sda = !(sda_oe || slv_pull);
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk_eq("R1 busy in reset", int'(busy), 0);
      chk_eq("R1 done in reset", int'(done), 0);
      chk_eq("R1 error in reset", int'(nack_err), 0);
      chk_eq("R1 result in reset", int'(result), 0);
      chk_eq("R1 lines in reset", int'({scl_oe, sda_oe}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 idle after reset", int'({busy, done, scl_oe, sda_oe}), 0);
   endtask

   task automatic run(input bit poke);
      lg_rd.delete(); lg_rises.delete(); lg_b0.delete(); lg_b1.delete();
      lg_b2.delete(); lg_mack.delete(); lg_mnack.delete();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_eq("R12 busy after accepted start", int'(busy), 1);
      if (poke) begin
         repeat (100) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (30) @(negedge clk);
      chk_eq("R12 no transaction after completion", int'(busy), 0);
   endtask

   task automatic check_write(input int idx, input int n);
      chk_eq("R5 write direction", lg_rd[idx], 0);
      chk_eq("R5 write pulse count", lg_rises[idx], n);
      chk_eq("R5 address byte 0x6C", lg_b0[idx], 8'h6C);
      if (n == 27) begin
         chk_eq("R5 setup byte 0xD2", lg_b1[idx], 8'hD2);
         chk_eq("R5 configuration byte 0x61", lg_b2[idx], 8'h61);
      end
   endtask

   task automatic check_read(input int idx);
      chk_eq("R7 read direction", lg_rd[idx], 1);
      chk_eq("R7 read pulse count", lg_rises[idx], 27 + CONV);
      chk_eq("R7 address byte 0x6D", lg_b0[idx], 8'h6D);
      chk_eq("R7 master ack after high byte", lg_mack[idx], 0);
      chk_eq("R7 master no-ack after low byte", lg_mnack[idx], 1);
   endtask

   initial begin
      int dn;
      do_reset();

      // first request: program then read
      smp = 10'h2A5;
      run(0);
      chk_eq("R5 two transactions", lg_rd.size(), 2);
      if (lg_rd.size() == 2) begin check_write(0, 27); check_read(1); end
      chk_eq("R8 result 0x2A5", int'(result), 10'h2A5);
      chk_eq("R8 one done", done_cnt, 1);
      chk_eq("R10 no error", int'(nack_err), 0);

      // later request, start poked while busy
      smp = 10'h3FF;
      run(1);
      chk_eq("R6 read only", lg_rd.size(), 1);
      if (lg_rd.size() == 1) check_read(0);
      chk_eq("R8 result 0x3FF", int'(result), 10'h3FF);
      chk_eq("R12 extra start ignored", done_cnt, 2);

      smp = 10'h000;
      run(0);
      chk_eq("R8 result 0x000", int'(result), 0);
      smp = 10'h15A;
      run(0);
      chk_eq("R8 result 0x15A", int'(result), 10'h15A);
      chk_eq("R6 read only again", lg_rd.size(), 1);

      // refused read address
      dn = done_cnt;
      nack_rd = 9; smp = 10'h0F0;
      run(0);
      chk_eq("R10 aborted after ack slot", (lg_rises.size() == 1) ? lg_rises[0] : -1, 9);
      chk_eq("R10 error set", int'(nack_err), 1);
      chk_eq("R10 no done", done_cnt, dn);
      chk_eq("R10 result kept", int'(result), 10'h15A);

      nack_rd = 0; smp = 10'h1C3;
      run(0);
      chk_eq("R10 result after recovery", int'(result), 10'h1C3);
      chk_eq("R10 error sticky", int'(nack_err), 1);

      // refused setup byte after fresh reset
      do_reset();
      dn = done_cnt;
      nack_wr = 18; smp = 10'h2DB;
      run(0);
      chk_eq("R11 single aborted write", lg_rd.size(), 1);
      if (lg_rd.size() == 1) check_write(0, 18);
      chk_eq("R11 error set", int'(nack_err), 1);
      chk_eq("R11 no done", done_cnt, dn);

      nack_wr = 0;
      run(0);
      chk_eq("R11 write repeated", lg_rd.size(), 2);
      if (lg_rd.size() == 2) begin check_write(0, 27); check_read(1); end
      chk_eq("R11 result 0x2DB", int'(result), 10'h2DB);

      summary();
      $finish;
   end
endmodule